// File: doc/BRIEF.md
# SPI Module Register and Interrupt Hub

This block is the shared register front end of a four-channel SPI controller. It decodes a 32-bit register bus and holds the module-wide registers: system configuration, wakeup enable, system test, module control, interrupt status and interrupt enable. It steers every access that lands in a channel's window to that channel, using a one-hot select and a register index. The per-channel transfer engines sit outside the block. Each of them reports two events to it: transmit-empty and receive-full.

Events are collected into a sticky status word. Each channel owns a fixed 4-bit lane of that word, and software clears bits by writing ones to them. A single level interrupt is raised whenever a status bit and its enable bit are both set. A test mode exists for exercising the interrupt path. It can force every implemented status bit high and then hold those bits against clearing. Writing the soft-reset bit of the system configuration register returns all module registers to their reset values and sends a one-cycle reset pulse to the channels.

Top module: `spi_irq_hub`

## Requirements
- R1: A pulse on the transmit-empty event of channel n sets status bit 4n, and a pulse on its receive-full event sets status bit 4n+2. These bits stay set until they are cleared; the pulse that sets them is visible from the cycle after it.
- R2: The interrupt output is high exactly when some bit is set in both the status register (offset 0x18) and the enable register (offset 0x1C). Writes to the enable register keep only the bits in mask 0x1777F.
- R3: A write to the status register clears each status bit that is written as 1 and leaves the bits written as 0 unchanged.
- R4: While module control bit 3 and system-test bit 11 are both set, writes to the status register clear nothing.
- R5: Either of two writes sets every status bit in mask 0x1777F: a system-test write with bit 11 set while module control bit 3 is set, or a module control write with bit 3 set while system-test bit 11 is set.
- R6: Writes are masked per register. System configuration (0x10) keeps mask 0x31D. Wakeup enable (0x20) keeps bit 0. System test (0x24) keeps bits 11:0. Module control (0x28) keeps bits 3:0.
- R7: A write to 0x10 with bit 1 set is a soft reset. Module control goes to 4, and status, enable, wakeup and system test go to 0. System configuration takes the written value masked by 0x31D. The channel reset output pulses high for one cycle. Event pulses that arrive in the same cycle still set their status bits.
- R8: After a hardware reset, module control reads 4 and every other module register reads 0. Offset 0x00 always reads 0x91, and offset 0x14 always reads 1. Writes to these two offsets have no effect.
- R9: Offset 0x2C + 0x14*n + 4*r addresses register r of channel n. The register order is r=0 config, 1 status, 2 control, 3 transmit, 4 receive. An access to that offset asserts select bit n with index r, and a read returns lane n of the channel read-data bus. The channel write strobe is asserted only for writes where r is 0, 2 or 3.
- R10: A read from an unmapped or unaligned offset returns 0, and a write to one changes nothing. In both cases the error output is high for exactly the cycle after the access.
- R11: When an event pulse and a status write that clears the same bit arrive in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, zero when idle |
| busErr | output | 1 | One-cycle pulse after an unmapped access |
| chSel | output | 4 | One-hot channel select for window accesses |
| chReg | output | 3 | Channel register index |
| chWr | output | 1 | Write strobe for writable channel registers |
| chWdata | output | 32 | Write data toward the channels |
| chRdata | input | 128 | Channel read data, 32 bits per channel, channel 0 lowest |
| txEmptyEv | input | 4 | Transmit-empty event pulses, one per channel |
| rxFullEv | input | 4 | Receive-full event pulses, one per channel |
| swReset | output | 1 | Soft-reset pulse to the channels |
| irqOut | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: four channels, an 8-bit offset bus and a 0x14-byte channel stride. With these values every channel window, and its boundary with unmapped space, lies inside the 256-byte offset range. The bench can therefore sweep all twenty channel offsets, the gap at 0x04 to 0x0C, and the space above 0x7B. Because all four 4-bit lanes are present, the full 0x1777F force mask is reachable, and the random mix can land events in every lane while test mode switches on and off.

// File: rtl/spi_hub_pkg.sv
package spi_hub_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_REV,
    SEL_SYSC,
    SEL_SYSS,
    SEL_STAT,
    SEL_EN,
    SEL_WAKE,
    SEL_SYST,
    SEL_CTRL,
    SEL_CHAN
  } regSel_e;

  // strobes from the decoder to the register datapath
  typedef struct packed {
    logic wrSysc;
    logic wrStat;
    logic wrEn;
    logic wrWake;
    logic wrSyst;
    logic wrCtrl;
    logic badAcc;
  } hubStrobe_t;

  localparam logic [31:0] REV_VALUE  = 32'h0000_0091;
  localparam logic [31:0] SYSC_MASK  = 32'h0000_031D;
  localparam int          SYST_W     = 12;
  localparam int          CTRL_W     = 4;
  localparam logic [3:0]  CTRL_RESET = 4'h4;
  localparam int          CH_REGS    = 5;

endpackage

// File: rtl/spi_hub_ctrl.sv
module spi_hub_ctrl
  import spi_hub_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 8,
  parameter int CH_BASE   = 'h2C,
  parameter int CH_STRIDE = 'h14
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output hubStrobe_t        strb,
  output regSel_e           rdSel,
  output logic [NUM_CH-1:0] chSel,
  output logic [2:0]        chReg,
  output logic              chWr
);

  logic [NUM_CH-1:0] hitVec;
  logic [2:0]        hitReg;
  logic              wrAcc;

  assign wrAcc = busSel && busWrite;

  // channel window decode
  always_comb begin
    hitVec = '0;
    hitReg = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      for (int r = 0; r < CH_REGS; r++) begin
        if (busAddr == ADDR_W'(CH_BASE + n * CH_STRIDE + 4 * r)) begin
          hitVec[n] = 1'b1;
          hitReg    = 3'(r);
        end
      end
    end
  end

  // module register decode
  always_comb begin
    rdSel = SEL_NONE;
    if (|hitVec) begin
      rdSel = SEL_CHAN;
    end else begin
      case (busAddr)
        ADDR_W'('h00): rdSel = SEL_REV;
        ADDR_W'('h10): rdSel = SEL_SYSC;
        ADDR_W'('h14): rdSel = SEL_SYSS;
        ADDR_W'('h18): rdSel = SEL_STAT;
        ADDR_W'('h1C): rdSel = SEL_EN;
        ADDR_W'('h20): rdSel = SEL_WAKE;
        ADDR_W'('h24): rdSel = SEL_SYST;
        ADDR_W'('h28): rdSel = SEL_CTRL;
        default:       rdSel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strb.wrSysc = wrAcc && (rdSel == SEL_SYSC);
    strb.wrStat = wrAcc && (rdSel == SEL_STAT);
    strb.wrEn   = wrAcc && (rdSel == SEL_EN);
    strb.wrWake = wrAcc && (rdSel == SEL_WAKE);
    strb.wrSyst = wrAcc && (rdSel == SEL_SYST);
    strb.wrCtrl = wrAcc && (rdSel == SEL_CTRL);
    strb.badAcc = busSel && (rdSel == SEL_NONE);
  end

  // status (1) and receive (4) are read-only on the channel side
  assign chSel = busSel ? hitVec : '0;
  assign chReg = hitReg;
  assign chWr  = wrAcc && (|hitVec) && (hitReg != 3'd1) && (hitReg != 3'd4);

endmodule

// File: rtl/spi_hub_regs.sv
module spi_hub_regs
  import spi_hub_pkg::*;
#(
  parameter int          NUM_CH    = 4,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] STAT_MASK = 32'h0001_777F
) (
  input  logic              clk,
  input  logic              rstN,
  input  hubStrobe_t        strb,
  input  regSel_e           rdSel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] txEv,
  input  logic [NUM_CH-1:0] rxEv,
  output logic [DATA_W-1:0] modRdata,
  output logic [DATA_W-1:0] statQ,
  output logic [DATA_W-1:0] enQ,
  output logic [SYST_W-1:0] systQ,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              irq,
  output logic              errPulse,
  output logic              swReset
);

  localparam logic [DATA_W-1:0] MASK_W = DATA_W'(STAT_MASK);

  logic [DATA_W-1:0] syscQ;
  logic              wakeQ;
  logic [DATA_W-1:0] evSet;
  logic [DATA_W-1:0] statNext;
  logic              holdClr;
  logic              forceAll;
  logic              softHit;

  // each channel owns a 4-bit lane: bit 0 tx empty, bit 2 rx full
  always_comb begin
    evSet = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      evSet[4 * n]     = txEv[n];
      evSet[4 * n + 2] = rxEv[n];
    end
  end

  assign holdClr  = ctrlQ[3] && systQ[11];
  assign forceAll = (strb.wrSyst && ctrlQ[3] && wdata[11]) ||
                    (strb.wrCtrl && wdata[3] && systQ[11]);
  assign softHit  = strb.wrSysc && wdata[1];

  always_comb begin
    statNext = statQ;
    if (strb.wrStat && !holdClr) statNext = statNext & ~wdata;
    if (forceAll)                statNext = statNext | MASK_W;
    statNext = statNext | evSet;  // set beats clear
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syscQ    <= '0;
      wakeQ    <= 1'b0;
      statQ    <= '0;
      enQ      <= '0;
      systQ    <= '0;
      ctrlQ    <= CTRL_RESET;
      errPulse <= 1'b0;
      swReset  <= 1'b0;
    end else begin
      errPulse <= strb.badAcc;
      swReset  <= softHit;
      if (softHit) begin
        syscQ <= wdata & DATA_W'(SYSC_MASK);
        wakeQ <= 1'b0;
        statQ <= evSet;
        enQ   <= '0;
        systQ <= '0;
        ctrlQ <= CTRL_RESET;
      end else begin
        statQ <= statNext;
        if (strb.wrSysc) syscQ <= wdata & DATA_W'(SYSC_MASK);
        if (strb.wrEn)   enQ   <= wdata & MASK_W;
        if (strb.wrWake) wakeQ <= wdata[0];
        if (strb.wrSyst) systQ <= wdata[SYST_W-1:0];
        if (strb.wrCtrl) ctrlQ <= wdata[CTRL_W-1:0];
      end
    end
  end

  assign irq = |(statQ & enQ);

  always_comb begin
    case (rdSel)
      SEL_REV:  modRdata = DATA_W'(REV_VALUE);
      SEL_SYSC: modRdata = syscQ;
      SEL_SYSS: modRdata = DATA_W'(1);
      SEL_STAT: modRdata = statQ;
      SEL_EN:   modRdata = enQ;
      SEL_WAKE: modRdata = DATA_W'(wakeQ);
      SEL_SYST: modRdata = DATA_W'(systQ);
      SEL_CTRL: modRdata = DATA_W'(ctrlQ);
      default:  modRdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_irq_hub.sv
module spi_irq_hub
  import spi_hub_pkg::*;
#(
  parameter int          NUM_CH    = 4,
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter int          CH_BASE   = 'h2C,
  parameter int          CH_STRIDE = 'h14,
  parameter logic [31:0] STAT_MASK = 32'h0001_777F
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busSel,
  input  logic                     busWrite,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [DATA_W-1:0]        busWdata,
  output logic [DATA_W-1:0]        busRdata,
  output logic                     busErr,
  output logic [NUM_CH-1:0]        chSel,
  output logic [2:0]               chReg,
  output logic                     chWr,
  output logic [DATA_W-1:0]        chWdata,
  input  logic [NUM_CH*DATA_W-1:0] chRdata,
  input  logic [NUM_CH-1:0]        txEmptyEv,
  input  logic [NUM_CH-1:0]        rxFullEv,
  output logic                     swReset,
  output logic                     irqOut
);

  hubStrobe_t        strb;
  regSel_e           rdSel;
  logic [DATA_W-1:0] modRdata;
  logic [DATA_W-1:0] chLane;
  logic [DATA_W-1:0] statQ;
  logic [DATA_W-1:0] enQ;
  logic [SYST_W-1:0] systQ;
  logic [CTRL_W-1:0] ctrlQ;

  spi_hub_ctrl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
  ) uCtrl (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .strb(strb), .rdSel(rdSel), .chSel(chSel), .chReg(chReg), .chWr(chWr)
  );

  spi_hub_regs #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .STAT_MASK(STAT_MASK)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .wdata(busWdata),
    .txEv(txEmptyEv), .rxEv(rxFullEv), .modRdata(modRdata),
    .statQ(statQ), .enQ(enQ), .systQ(systQ), .ctrlQ(ctrlQ),
    .irq(irqOut), .errPulse(busErr), .swReset(swReset)
  );

  always_comb begin
    chLane = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (chSel[n]) chLane = chRdata[n * DATA_W +: DATA_W];
    end
  end

  assign chWdata  = busWdata;
  assign busRdata = !busSel ? '0 : (rdSel == SEL_CHAN) ? chLane : modRdata;

endmodule

// File: rtl/spi_irq_hub_chk.sv
module spi_irq_hub_chk #(
  parameter int          NUM_CH    = 4,
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] STAT_MASK = 32'h0001_777F
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busErr,
  input logic [NUM_CH-1:0] chSel,
  input logic [2:0]        chReg,
  input logic              chWr,
  input logic [NUM_CH-1:0] txEmptyEv,
  input logic [NUM_CH-1:0] rxFullEv,
  input logic              swReset,
  input logic              irqOut,
  input logic [DATA_W-1:0] statQ,
  input logic [DATA_W-1:0] enQ,
  input logic [11:0]       systQ,
  input logic [3:0]        ctrlQ
);

  logic wrStatus, wrSyst, wrCtrl, softWr;
  assign wrStatus = busSel && busWrite && (busAddr == ADDR_W'('h18));
  assign wrSyst   = busSel && busWrite && (busAddr == ADDR_W'('h24));
  assign wrCtrl   = busSel && busWrite && (busAddr == ADDR_W'('h28));
  assign softWr   = busSel && busWrite && (busAddr == ADDR_W'('h10)) && busWdata[1];

  for (genvar n = 0; n < NUM_CH; n++) begin : gLane
    a_r1_tx_sets: assert property (@(posedge clk) disable iff (!rstN)
      txEmptyEv[n] |=> statQ[4 * n]);
    a_r1_rx_sets: assert property (@(posedge clk) disable iff (!rstN)
      rxFullEv[n] |=> statQ[4 * n + 2]);
  end

  a_r2_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == '0) |-> !irqOut);

  a_r3_clear_bit: assert property (@(posedge clk) disable iff (!rstN)
    (wrStatus && !(ctrlQ[3] && systQ[11]) && busWdata[2] && !rxFullEv[0])
      |=> !statQ[2]);

  a_r4_hold_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (wrStatus && ctrlQ[3] && systQ[11])
      |=> ((statQ & $past(statQ)) == $past(statQ)));

  a_r5_force_by_syst: assert property (@(posedge clk) disable iff (!rstN)
    (wrSyst && ctrlQ[3] && busWdata[11])
      |=> ((statQ & DATA_W'(STAT_MASK)) == DATA_W'(STAT_MASK)));

  a_r5_force_by_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && busWdata[3] && systQ[11])
      |=> ((statQ & DATA_W'(STAT_MASK)) == DATA_W'(STAT_MASK)));

  a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    softWr |=> (swReset && ctrlQ == 4'h4 && enQ == '0 && systQ == '0));

  a_r9_ro_no_write: assert property (@(posedge clk) disable iff (!rstN)
    chWr |-> (chReg != 3'd1 && chReg != 3'd4 && $onehot0(chSel) && chSel != '0));

  a_r9_select_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chSel));

  a_r10_err_after_access: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busSel));

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (txEmptyEv[0] && wrStatus && busWdata[0]) |=> statQ[0]);

endmodule

bind spi_irq_hub spi_irq_hub_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_MASK(STAT_MASK)
) uChk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busErr(busErr),
  .chSel(chSel), .chReg(chReg), .chWr(chWr),
  .txEmptyEv(txEmptyEv), .rxFullEv(rxFullEv), .swReset(swReset),
  .irqOut(irqOut), .statQ(statQ), .enQ(enQ), .systQ(systQ), .ctrlQ(ctrlQ)
);

// File: tb/sim_spi_irq_hub.sv
module sim_spi_irq_hub;

  localparam logic [31:0] MASK = 32'h0001_777F;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busSel = 1'b0;
  logic         busWrite = 1'b0;
  logic [7:0]   busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic         busErr;
  logic [3:0]   chSel;
  logic [2:0]   chReg;
  logic         chWr;
  logic [31:0]  chWdata;
  logic [127:0] chRdata;
  logic [3:0]   txEmptyEv = '0;
  logic [3:0]   rxFullEv = '0;
  logic         swReset;
  logic         irqOut;

  int checks = 0;
  int errors = 0;

  // bench model of the module registers
  logic [31:0] mSysc, mStat, mEn;
  logic        mWake;
  logic [11:0] mSyst;
  logic [3:0]  mCtrl;
  logic        mSoft;

  // sampled during an access
  logic [31:0] sRd;
  logic [3:0]  sSel;
  logic [2:0]  sReg;
  logic        sWr;
  logic        sErr, sSoft;

  always #10 clk = ~clk;

  spi_irq_hub u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busErr(busErr), .chSel(chSel), .chReg(chReg), .chWr(chWr),
    .chWdata(chWdata), .chRdata(chRdata), .txEmptyEv(txEmptyEv),
    .rxFullEv(rxFullEv), .swReset(swReset), .irqOut(irqOut)
  );

  // each channel returns a tag naming itself and the requested register
  always_comb begin
    for (int n = 0; n < 4; n++)
      chRdata[n * 32 +: 32] = {16'hA5A5, 8'(n), 5'b0, chReg};
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic bit isChan(input logic [7:0] a);
    return (a >= 8'h2C) && (a <= 8'h78) && (a[1:0] == 2'b00);
  endfunction

  function automatic int chanOf(input logic [7:0] a);
    return (int'(a) - 'h2C) / 'h14;
  endfunction

  function automatic int regOf(input logic [7:0] a);
    return ((int'(a) - 'h2C) % 'h14) / 4;
  endfunction

  function automatic bit isMapped(input logic [7:0] a);
    case (a)
      8'h00, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28: return 1'b1;
      default: return isChan(a);
    endcase
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h00: return 32'h91;
      8'h10: return mSysc;
      8'h14: return 32'h1;
      8'h18: return mStat;
      8'h1C: return mEn;
      8'h20: return {31'b0, mWake};
      8'h24: return {20'b0, mSyst};
      8'h28: return {28'b0, mCtrl};
      default:
        if (isChan(a)) return {16'hA5A5, 8'(chanOf(a)), 5'b0, 3'(regOf(a))};
        else return 32'h0;
    endcase
  endfunction

  task automatic mdlApply(input bit wr, input logic [7:0] a, input logic [31:0] d,
                          input logic [3:0] tx, input logic [3:0] rx);
    logic [31:0] ev;
    bit hold, frc;
    ev = '0;
    for (int n = 0; n < 4; n++) begin
      ev[4 * n]     = tx[n];
      ev[4 * n + 2] = rx[n];
    end
    mSoft = 1'b0;
    if (wr && a == 8'h10 && d[1]) begin
      mSysc = d & 32'h31D; mStat = ev; mEn = '0; mWake = 1'b0;
      mSyst = '0; mCtrl = 4'h4; mSoft = 1'b1;
      return;
    end
    hold = mCtrl[3] && mSyst[11];
    frc  = 1'b0;
    if (wr) begin
      case (a)
        8'h10: mSysc = d & 32'h31D;
        8'h18: if (!hold) mStat = mStat & ~d;
        8'h1C: mEn = d & MASK;
        8'h20: mWake = d[0];
        8'h24: begin if (mCtrl[3] && d[11]) frc = 1'b1; mSyst = d[11:0]; end
        8'h28: begin if (d[3] && mSyst[11]) frc = 1'b1; mCtrl = d[3:0]; end
        default: ;
      endcase
    end
    if (frc) mStat = mStat | MASK;
    mStat = mStat | ev;
  endtask

  // one bus access plus event pulses; checks routing, read data, error, irq
  task automatic acc(input bit wr, input logic [7:0] a, input logic [31:0] d,
                     input logic [3:0] tx, input logic [3:0] rx);
    logic [31:0] er;
    bit mp, ewr;
    @(negedge clk);
    busSel = 1'b1; busWrite = wr; busAddr = a; busWdata = d;
    txEmptyEv = tx; rxFullEv = rx;
    #1;
    sRd = busRdata; sSel = chSel; sReg = chReg; sWr = chWr;
    er  = expRead(a);
    mp  = isMapped(a);
    if (!wr) chk(sRd == er, isChan(a) ? "R9" : (mp ? "R8" : "R10"), sRd, er);
    if (isChan(a)) begin
      chk(sSel == 4'(1 << chanOf(a)) && sReg == 3'(regOf(a)), "R9",
          {25'b0, sReg, sSel}, {25'b0, 3'(regOf(a)), 4'(1 << chanOf(a))});
      ewr = wr && regOf(a) != 1 && regOf(a) != 4;
      chk(sWr == ewr, "R9", 32'(sWr), 32'(ewr));
    end else begin
      chk(sSel == 4'b0 && !sWr, "R9", {27'b0, sWr, sSel}, 32'h0);
    end
    mdlApply(wr, a, d, tx, rx);
    @(posedge clk);
    #1;
    sErr = busErr; sSoft = swReset;
    busSel = 1'b0; txEmptyEv = '0; rxFullEv = '0;
    chk(sErr == !mp, "R10", 32'(sErr), 32'(!mp));
    chk(sSoft == mSoft, "R7", 32'(sSoft), 32'(mSoft));
    chk(irqOut == |(mStat & mEn), "R2", 32'(irqOut), 32'(|(mStat & mEn)));
  endtask

  task automatic rdChk(input logic [7:0] a, input string req);
    logic [31:0] e;
    e = expRead(a);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1;
    chk(busRdata == e, req, busRdata, e);
    @(posedge clk);
    #1;
    busSel = 1'b0;
  endtask

  task automatic hwReset();
    rstN = 1'b0;
    mSysc = '0; mStat = '0; mEn = '0; mWake = 1'b0; mSyst = '0; mCtrl = 4'h4;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  initial begin : watchdog
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [7:0]  a;
    logic [31:0] d;
    int pick;
    void'($urandom(32'd2024));
    hwReset();

    // R8: reset values and constants
    chk(!irqOut && !busErr && !swReset, "R8", {29'b0, irqOut, busErr, swReset}, 32'h0);
    rdChk(8'h00, "R8"); rdChk(8'h14, "R8"); rdChk(8'h28, "R8");
    rdChk(8'h18, "R8"); rdChk(8'h1C, "R8"); rdChk(8'h24, "R8");
    rdChk(8'h10, "R8"); rdChk(8'h20, "R8");
    acc(1, 8'h00, 32'hFFFF_FFFF, 0, 0); rdChk(8'h00, "R8");
    acc(1, 8'h14, 32'hFFFF_FFFF, 0, 0); rdChk(8'h14, "R8");

    // R6: write masks
    acc(1, 8'h10, 32'hFFFF_FFFD, 0, 0); rdChk(8'h10, "R6");
    acc(1, 8'h20, 32'hFFFF_FFFF, 0, 0); rdChk(8'h20, "R6");
    acc(1, 8'h24, 32'hFFFF_F7FF, 0, 0); rdChk(8'h24, "R6");
    acc(1, 8'h28, 32'hFFFF_FFF7, 0, 0); rdChk(8'h28, "R6");
    acc(1, 8'h1C, 32'hFFFF_FFFF, 0, 0); rdChk(8'h1C, "R2");

    // R1: events land in their lanes
    for (int n = 0; n < 4; n++) begin
      acc(0, 8'h04, 0, 4'(1 << n), 0); rdChk(8'h18, "R1");
      acc(0, 8'h04, 0, 0, 4'(1 << n)); rdChk(8'h18, "R1");
    end
    // R3: write-one-to-clear, partial
    acc(1, 8'h18, 32'h0000_0105, 0, 0); rdChk(8'h18, "R3");
    // R11: set wins
    acc(1, 8'h18, 32'hFFFF_FFFF, 4'b0010, 0); rdChk(8'h18, "R11");
    // R2: irq drops when enable cleared
    acc(1, 8'h1C, 32'h0, 0, 0);
    acc(1, 8'h1C, 32'h0000_0010, 0, 0);

    // R5: force via system-test write with test mode on
    acc(1, 8'h28, 32'h8, 0, 0);
    acc(1, 8'h24, 32'h800, 0, 0); rdChk(8'h18, "R5");
    // R4: clear ignored while held
    acc(1, 8'h18, 32'hFFFF_FFFF, 0, 0); rdChk(8'h18, "R4");
    // leave test mode, clear works
    acc(1, 8'h28, 32'h0, 0, 0);
    acc(1, 8'h18, 32'hFFFF_FFFF, 0, 0); rdChk(8'h18, "R3");
    // R5: force via entering test mode with bit 11 already set
    acc(1, 8'h28, 32'hC, 0, 0); rdChk(8'h18, "R5");

    // R7: soft reset with a simultaneous event
    acc(1, 8'h10, 32'hFFFF_FFFF, 0, 4'b1000);
    rdChk(8'h10, "R7"); rdChk(8'h28, "R7"); rdChk(8'h18, "R7");
    rdChk(8'h24, "R7"); rdChk(8'h1C, "R7");

    // R9/R10: sweep every offset once for reads, writes leave state alone
    for (int i = 0; i < 256; i++) acc(0, 8'(i), 0, 0, 0);
    for (int i = 4; i < 16; i++) acc(1, 8'(i), 32'hFFFF_FFFF, 0, 0);
    for (int i = 124; i < 256; i++) acc(1, 8'(i), 32'hFFFF_FFFF, 0, 0);
    rdChk(8'h10, "R10"); rdChk(8'h18, "R10"); rdChk(8'h1C, "R10");
    rdChk(8'h24, "R10"); rdChk(8'h28, "R10"); rdChk(8'h20, "R10");

    // random mix
    for (int it = 0; it < 3000; it++) begin
      pick = $urandom_range(0, 11);
      case (pick)
        0:  a = 8'h00;  1: a = 8'h10;  2: a = 8'h14;  3: a = 8'h18;
        4:  a = 8'h1C;  5: a = 8'h20;  6: a = 8'h24;  7: a = 8'h28;
        8:  a = 8'(8'h2C + 4 * $urandom_range(0, 19));
        9:  a = 8'($urandom);
        default: a = 8'h18;
      endcase
      d = $urandom;
      if (a == 8'h10 && ($urandom_range(0, 7) != 0)) d[1] = 1'b0;
      acc($urandom_range(0, 1) == 1, a, d, 4'($urandom), 4'($urandom));
      if ((it % 16) == 0) rdChk(8'h18, "R1");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule